// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves a single external interrupt request pin. It passes the pin through a synchroniser and watches it for a chosen transition: falling or rising, optionally extended to the matching steady level. A qualifying event sets a pending flag. The CPU reads that flag through one 8-bit status and control register on a simple bus, which has an address, a write enable, write data and combinational read data. Software clears the flag by writing a one to a self-clearing acknowledge bit. When the interrupt-enable bit is set, a pending flag drives the interrupt request output.

The block also drives the pad's pull resistor. A single polarity bit chooses the transition that is detected and also chooses whether the pad pull acts upward or downward. A separate disable bit turns the pull off entirely. While the pin function is off, the block detects nothing and both pull controls stay low.

The pending flag is held by a two-state machine. In state `FLG_IDLE` the flag reads 0. In state `FLG_PENDING` the flag reads 1. Transition `T_DETECT` goes from `FLG_IDLE` to `FLG_PENDING` on a qualifying event. Transition `T_ACK` goes from `FLG_PENDING` to `FLG_IDLE` on an acknowledge write in a cycle with no qualifying event. In every other cycle the state holds.

Top module: `extint_ctrl`

## Requirements
- R1: The register reads as {0, pull_off(6), polarity(5), pin_on(4), flag(3), 0, irq_on(1), level_mode(0)}, with bit numbers in brackets. Bit 7 and bit 2 always read 0. After reset every bit is 0.
- R2: The pin passes through two synchronising flops, and a third flop holds the previous sample. When the pin changes before clock edge k, the resulting flag is visible after edge k+2.
- R3: With polarity=0 a falling transition qualifies. With polarity=1 a rising transition qualifies.
- R4: With level_mode=0 only transitions set the flag. With level_mode=1, a synchronised pin equal to the polarity bit sets the flag in every cycle.
- R5: While pin_on=0 no event is detected, so the flag keeps its value, and pullup_en and pulldown_en are both 0.
- R6: Writes to bit 3 are ignored. The flag changes only through detection and acknowledge.
- R7: A write with bit 2 set clears the flag. In level mode with the pin still at its active level, the flag stays 1.
- R8: If an acknowledge write and a qualifying event fall in the same cycle, the flag remains 1.
- R9: irq_req equals flag AND irq_on. It follows the new irq_on from the clock edge that takes the write.
- R10: When pin_on=1 and pull_off=0, pullup_en=1 if polarity=0 and pulldown_en=1 if polarity=1. When pull_off=1 both are 0. The two are never 1 together.
- R11: Reads at any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 1 | Raw external request pin |
| irq_req | output | 1 | Interrupt request to the CPU |
| pullup_en | output | 1 | Pad pull-up enable |
| pulldown_en | output | 1 | Pad pull-down enable |

## Verification
The acknowledge write and a fresh qualifying event can land on the same clock edge. That is the case where `T_ACK` must give way to `T_DETECT`. The bench provokes it by changing the pin and timing an acknowledge write to be sampled exactly two edges later, when the synchronised transition reaches the detector. It also acknowledges in level mode while holding the pin at its active level. In both cases the flag must still read 1 afterwards. The random phase overlaps pin activity with random writes, so further collisions of this kind occur, and a cycle-level reference model judges every one of them.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int REG_W  = 8;
    localparam int B_MODE = 0;
    localparam int B_IE   = 1;
    localparam int B_ACK  = 2;
    localparam int B_FLAG = 3;
    localparam int B_PE   = 4;
    localparam int B_POL  = 5;
    localparam int B_PDD  = 6;

    typedef enum logic {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_t;

    typedef struct packed {
        logic pull_off;
        logic pol;
        logic pin_on;
        logic irq_on;
        logic lvl_mode;
    } ctl_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  ctl_t ctl,
    output logic evt
);
    logic prev_q;
    logic at_level;
    logic changed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    always_comb begin
        at_level = (pin_s == ctl.pol);
        changed  = (pin_s != prev_q);
        if (!ctl.pin_on)       evt = 1'b0;
        else if (ctl.lvl_mode) evt = at_level;
        else                   evt = at_level && changed;
    end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              flag,
    output ctl_t              ctl,
    output logic              ack_wr,
    output logic [REG_W-1:0]  bus_rdata
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

    logic hit;
    logic unused_wbits;

    assign hit          = (bus_addr == SEL_ADDR);
    assign unused_wbits = ^{bus_wdata[7], bus_wdata[B_FLAG]};
    assign ack_wr       = hit && bus_wr && bus_wdata[B_ACK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (hit && bus_wr) begin
            ctl.pull_off <= bus_wdata[B_PDD];
            ctl.pol      <= bus_wdata[B_POL];
            ctl.pin_on   <= bus_wdata[B_PE];
            ctl.irq_on   <= bus_wdata[B_IE];
            ctl.lvl_mode <= bus_wdata[B_MODE];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[B_PDD]  = ctl.pull_off;
            bus_rdata[B_POL]  = ctl.pol;
            bus_rdata[B_PE]   = ctl.pin_on;
            bus_rdata[B_FLAG] = flag;
            bus_rdata[B_IE]   = ctl.irq_on;
            bus_rdata[B_MODE] = ctl.lvl_mode;
        end
    end
endmodule

// File: rtl/extint_flag_fsm.sv
module extint_flag_fsm
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack,
    input  logic irq_on,
    output logic flag,
    output logic irq
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE:    if (evt)         state_d = FLG_PENDING; // T_DETECT
            FLG_PENDING: if (ack && !evt) state_d = FLG_IDLE;    // T_ACK
            default:                      state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_PENDING);
        irq  = flag && irq_on;
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int REG_ADDR    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pin_in,
    output logic              irq_req,
    output logic              pullup_en,
    output logic              pulldown_en
);
    ctl_t ctl;
    logic pin_s;
    logic evt;
    logic ack_wr;
    logic flag;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_s)
    );

    extint_detect u_detect (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_s(pin_s),
        .ctl  (ctl),
        .evt  (evt)
    );

    extint_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .flag     (flag),
        .ctl      (ctl),
        .ack_wr   (ack_wr),
        .bus_rdata(bus_rdata)
    );

    extint_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .ack   (ack_wr),
        .irq_on(ctl.irq_on),
        .flag  (flag),
        .irq   (irq_req)
    );

    always_comb begin
        pullup_en   = ctl.pin_on && !ctl.pull_off && !ctl.pol;
        pulldown_en = ctl.pin_on && !ctl.pull_off &&  ctl.pol;
    end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              irq_req,
    input logic              pullup_en,
    input logic              pulldown_en,
    input logic              pin_en,
    input logic              evt,
    input logic              ack_wr,
    input logic              flag
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_ADDR) |-> ((bus_rdata & 8'h84) == 8'h00));
    // R11
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != SEL_ADDR) |-> (bus_rdata == 8'h00));
    // R10
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pullup_en && pulldown_en));
    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> (!pullup_en && !pulldown_en && !evt));
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack_wr) |=> flag);
    // R7
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !evt) |=> !flag);
    // R6
    flag_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !evt) |=> !flag);
    // R8
    ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && evt) |=> flag);
    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> flag);
endmodule

bind extint_ctrl extint_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq_req    (irq_req),
    .pullup_en  (pullup_en),
    .pulldown_en(pulldown_en),
    .pin_en     (ctl.pin_on),
    .evt        (evt),
    .ack_wr     (ack_wr),
    .flag       (flag)
);

// File: tb/extint_ctrl_bench.sv
module extint_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int REG_ADDR   = 5;
    localparam int WATCHDOG   = 100000;
    localparam int N_RAND     = 4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = ADDR_W'(REG_ADDR);
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic              pin_in = 1'b1;
    logic              irq_req, pullup_en, pulldown_en;

    int n_checks = 0;
    int n_fails  = 0;

    // reference state
    logic m_s1, m_s2, m_prev, m_flag;
    logic m_pdd, m_pol, m_pe, m_ie, m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SYNC_STAGES(2)) u_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .irq_req(irq_req), .pullup_en(pullup_en), .pulldown_en(pulldown_en)
    );

    function automatic logic qualifies(logic s, logic p, logic pe, logic pol, logic mode);
        if (!pe) return 1'b0;
        if (mode) return s == pol;
        return (s == pol) && (s != p);
    endfunction

    function automatic logic [7:0] exp_rd(logic [ADDR_W-1:0] a);
        if (a != ADDR_W'(REG_ADDR)) return 8'h00;
        return {1'b0, m_pdd, m_pol, m_pe, m_flag, 1'b0, m_ie, m_mode};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
            m_pdd <= 0; m_pol <= 0; m_pe <= 0; m_ie <= 0; m_mode <= 0;
        end else begin
            logic hit_wr, ev;
            hit_wr = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));
            ev = qualifies(m_s2, m_prev, m_pe, m_pol, m_mode);
            m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
            m_flag <= ev || (m_flag && !(hit_wr && bus_wdata[2]));
            if (hit_wr) begin
                m_pdd <= bus_wdata[6]; m_pol <= bus_wdata[5]; m_pe <= bus_wdata[4];
                m_ie <= bus_wdata[1]; m_mode <= bus_wdata[0];
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " rdata"}, bus_rdata, exp_rd(bus_addr));
        chk({tag, " irq"}, {7'd0, irq_req}, {7'd0, m_flag && m_ie});
        chk({tag, " pullup"}, {7'd0, pullup_en}, {7'd0, m_pe && !m_pdd && !m_pol});
        chk({tag, " pulldown"}, {7'd0, pulldown_en}, {7'd0, m_pe && !m_pdd && m_pol});
    endtask

    task automatic cyc(string tag);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr_reg(string tag, logic [7:0] d);
        cyc(tag);
        bus_addr = ADDR_W'(REG_ADDR); bus_wr = 1'b1; bus_wdata = d;
        cyc(tag);
        bus_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 reset rdata", bus_rdata, 8'h00);
        chk("R1 reset outs", {5'd0, irq_req, pullup_en, pulldown_en}, 8'h00);
        idle("R1", 3);

        // R10 / R3: falling edge, pull-up
        wr_reg("R10", 8'h10);
        chk("R10 pullup", {6'd0, pullup_en, pulldown_en}, 8'h02);
        pin_in = 1'b0;
        cyc("R2"); cyc("R2");
        chk("R2 not yet", bus_rdata & 8'h08, 8'h00);
        cyc("R2");
        chk("R3 falling sets", bus_rdata & 8'h08, 8'h08);

        // R6: writing flag bit changes nothing
        wr_reg("R6", 8'h10);
        chk("R6 flag kept", bus_rdata & 8'h08, 8'h08);

        // R9: enable takes effect from the write edge
        wr_reg("R9", 8'h12);
        chk("R9 irq on", {7'd0, irq_req}, 8'h01);

        // R7: acknowledge clears
        wr_reg("R7", 8'h16);
        chk("R7 cleared", bus_rdata, 8'h12);
        chk("R9 irq off", {7'd0, irq_req}, 8'h00);
        wr_reg("R6", 8'h1A);
        chk("R6 no set", bus_rdata & 8'h08, 8'h00);

        // R3: rising, pull-down, falling edges ignored
        wr_reg("R10", 8'h30);
        chk("R10 pulldown", {6'd0, pullup_en, pulldown_en}, 8'h01);
        pin_in = 1'b1; idle("R3", 4);
        chk("R3 rising sets", bus_rdata & 8'h08, 8'h08);
        wr_reg("R7", 8'h34);
        pin_in = 1'b0; idle("R3", 4);
        chk("R3 falling ignored", bus_rdata & 8'h08, 8'h00);

        // R10: pull disabled
        wr_reg("R10", 8'h70);
        chk("R10 pull off", {6'd0, pullup_en, pulldown_en}, 8'h00);

        // R4 / R7: level mode keeps flag under ack
        pin_in = 1'b1; idle("R4", 4);
        wr_reg("R4", 8'h31);
        idle("R4", 2);
        wr_reg("R7", 8'h35);
        idle("R7", 1);
        chk("R7 level holds", bus_rdata & 8'h08, 8'h08);
        pin_in = 1'b0; idle("R4", 4);
        wr_reg("R7", 8'h35);
        chk("R4 level gone clears", bus_rdata & 8'h08, 8'h00);

        // R8: ack and edge on the same edge
        wr_reg("R8", 8'h10);
        pin_in = 1'b1; idle("R8", 4);
        wr_reg("R8", 8'h14);
        cyc("R8");
        pin_in = 1'b0;
        cyc("R8"); cyc("R8");
        bus_wr = 1'b1; bus_wdata = 8'h14;
        cyc("R8");
        bus_wr = 1'b0;
        chk("R8 set wins", bus_rdata & 8'h08, 8'h08);

        // R5: pin disabled
        wr_reg("R5", 8'h04);
        chk("R5 pulls off", {6'd0, pullup_en, pulldown_en}, 8'h00);
        pin_in = 1'b1; idle("R5", 3); pin_in = 1'b0; idle("R5", 4);
        chk("R5 no detect", bus_rdata & 8'h08, 8'h00);

        // R11: other address
        bus_addr = ADDR_W'(REG_ADDR + 1); bus_wr = 1'b1; bus_wdata = 8'h7F;
        cyc("R11");
        bus_wr = 1'b0;
        chk("R11 read zero", bus_rdata, 8'h00);
        bus_addr = ADDR_W'(REG_ADDR);
        cyc("R11");
        chk("R11 no write", bus_rdata, 8'h00);

        // random phase
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < N_RAND; i++) begin
            cyc("R2 R3 R4 R7 R8 R9 rand");
            if ($urandom_range(7) == 0) pin_in = ~pin_in;
            bus_addr = ($urandom_range(15) == 0) ? ADDR_W'($urandom) : ADDR_W'(REG_ADDR);
            bus_wr   = ($urandom_range(9) == 0);
            bus_wdata = 8'($urandom) | 8'h10;
        end
        bus_wr = 1'b0;
        cyc("end");
        summary();
    end
endmodule